// File: doc/BRIEF.md
# Brown-out Supervisor with Sticky Status Register

This block watches a low-supply flag produced by an external voltage comparator and decides whether a dip is real. The flag is synchronised into the clock domain. A duration filter then throws away dips shorter than a configurable number of clock cycles. When a dip is confirmed, the block takes one of two actions, chosen by a mode bit. It can gate the system clock enable for as long as the dip lasts. It can instead request a system reset, which it holds for a fixed number of cycles after the dip ends.

A single byte-wide register on a simple address/strobe bus holds three fields: a detection-off flag, the action mode and a sticky "power fail seen" flag. The sticky flag is not cleared by the reset the block requests. Only the separate cold-start input clears it. Start-up code can therefore read it and tell a brown-out restart from a power-on, and skip its memory initialisation when it sees a brown-out restart.

Top module: `pwrfail_supervisor`

## Requirements
- R1: After a cold start (`por_n` low), a read of the register address (0xEF) returns 0x04. Bit 2 (detection off) is 1, bit 1 (mode) is 0 and bit 0 (status) is 0. `clk_en_o` is 1 and `rst_req_o` is 0.
- R2: Bits 7 to 3 always read as 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: While bit 2 is 1, the comparator input has no effect: `clk_en_o` stays 1, `rst_req_o` stays 0 and the status bit stays 0.
- R4: The input passes two synchroniser flops and then a counter of FILT_CYCLES cycles. If the input goes high just before clock edge 1 and stays high for L edges, a detection occurs only if L >= FILT_CYCLES. The detection is registered at edge 2+FILT_CYCLES. Shorter pulses are ignored.
- R5: With mode 0, `clk_en_o` is 0 from edge 2+FILT_CYCLES through edge L+2, and returns to 1 at edge L+3.
- R6: With mode 1, `rst_req_o` rises at edge 3+FILT_CYCLES and stays high through edge L+2+RST_HOLD. In this mode `clk_en_o` stays 1.
- R7: A detection forces the status bit to 1, and the bit then stays 1 until it is cleared.
- R8: While `rst_req_o` is high, bits 2 and 1 return to 1 and 0, and register writes are ignored. The status bit keeps its value.
- R9: Writing 0 to bit 0 clears the status bit. Writing 1 to bit 0 has no effect. A detection in the same cycle as a clearing write wins, and the bit stays 1.
- R10: Only `por_n` clears the status bit.
- R11: A write to the register address sets bits 2 and 1 from the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Cold-start reset, active low, asynchronous |
| supply_low_i | input | 1 | Comparator low-supply flag, asynchronous |
| reg_addr | input | 8 | Register bus address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| clk_en_o | output | 1 | System clock enable, 0 while frozen |
| rst_req_o | output | 1 | System reset request, active high |

## Verification
The hardest situation to reach from the ports is the exact edge at which the filter either confirms a dip or drops it. Pulses of one cycle shorter and one cycle longer than the filter length must behave differently. The bench sweeps every pulse length from 1 to FILT_CYCLES+2 in both modes. For each length it predicts, cycle by cycle, the clock-enable and reset-request levels from the arithmetic edge windows in R4 to R6. A separate step holds the supply flag high while software issues a clearing write, which puts a detection and a clear in the same cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   // bit positions inside the configuration/status byte
   localparam int unsigned BIT_STS  = 0;
   localparam int unsigned BIT_MODE = 1;
   localparam int unsigned BIT_DIS  = 2;

   typedef struct packed {
      logic dis;
      logic mode;
      logic sts;
   } pfs_cfg_t;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_filter.sv
module pfs_filter #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sense,
   output logic active
);
   generate
      if (CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) active <= 1'b0;
            else        active <= en & sense;
         end
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(CYCLES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               active <= 1'b0;
            end else if (!en || !sense) begin
               cnt    <= '0;
               active <= 1'b0;
            end else if (cnt == LAST) begin
               active <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

   // R4
   no_early_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sense |=> !active);
   // R3
   off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !active);
endmodule

// File: rtl/pfs_action.sv
module pfs_action #(
   parameter int unsigned HOLD = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic mode,
   output logic rst_busy,
   output logic clk_en
);
   localparam int unsigned HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD);
   logic [HW-1:0] hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_busy <= 1'b0;
         hcnt     <= '0;
      end else if (!rst_busy) begin
         if (active && mode) begin
            rst_busy <= 1'b1;
            hcnt     <= HOLD_V;
         end
      end else if (active) begin
         hcnt <= HOLD_V;
      end else if (hcnt <= HW'(1)) begin
         rst_busy <= 1'b0;
         hcnt     <= '0;
      end else begin
         hcnt <= hcnt - 1'b1;
      end
   end

   // freeze only in mode 0 and never during a reset sequence
   assign clk_en = !(active && !mode && !rst_busy);

   // R6
   rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode && !rst_busy) |=> rst_busy);
   // R6
   hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_busy && !active && hcnt > HW'(1)) |=> rst_busy);
endmodule

// File: rtl/pfs_regs.sv
module pfs_regs
   import pfs_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'hEF)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              det,
   input  logic              rst_busy,
   output pfs_cfg_t          cfg
);
   logic hit, wr_hit;

   assign hit    = (addr == REG_ADDR);
   assign wr_hit = we && hit && !rst_busy;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg.dis  <= 1'b1;
         cfg.mode <= 1'b0;
      end else if (rst_busy) begin
         cfg.dis  <= 1'b1;
         cfg.mode <= 1'b0;
      end else if (wr_hit) begin
         cfg.dis  <= wdata[BIT_DIS];
         cfg.mode <= wdata[BIT_MODE];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                        cfg.sts <= 1'b0;
      else if (det)                      cfg.sts <= 1'b1;
      else if (wr_hit && !wdata[BIT_STS]) cfg.sts <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[BIT_DIS]  = cfg.dis;
         rdata[BIT_MODE] = cfg.mode;
         rdata[BIT_STS]  = cfg.sts;
      end
   end

   // R7
   sts_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      det |=> cfg.sts);
   // R9
   sts_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (cfg.sts && !(wr_hit && !wdata[BIT_STS])) |=> cfg.sts);
   // R8
   cfg_revert_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_busy |=> (cfg.dis && !cfg.mode));
endmodule

// File: rtl/pwrfail_supervisor.sv
module pwrfail_supervisor
   import pfs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'hEF),
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_CYCLES = 4,
   parameter int unsigned RST_HOLD    = 6
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              supply_low_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              clk_en_o,
   output logic              rst_req_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("FILT_CYCLES must be at least 1");
      end
      if (RST_HOLD < 1) begin : g_bad_hold
         $error("RST_HOLD must be at least 1");
      end
      if (DATA_W < 3) begin : g_bad_width
         $error("DATA_W must hold the three fields");
      end
   endgenerate

   logic     low_s, det, rst_busy, filt_en;
   pfs_cfg_t cfg;

   pfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(por_n), .d(supply_low_i), .q(low_s));

   // detection stays armed during a reset sequence even though the
   // off flag has been forced back to 1
   assign filt_en = !cfg.dis || rst_busy;

   pfs_filter #(.CYCLES(FILT_CYCLES)) u_filter (
      .clk(clk), .rst_n(por_n), .en(filt_en), .sense(low_s), .active(det));

   pfs_action #(.HOLD(RST_HOLD)) u_action (
      .clk(clk), .rst_n(por_n), .active(det), .mode(cfg.mode),
      .rst_busy(rst_busy), .clk_en(clk_en_o));

   pfs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regs (
      .clk(clk), .por_n(por_n), .addr(reg_addr), .we(reg_we),
      .wdata(reg_wdata), .rdata(reg_rdata), .det(det),
      .rst_busy(rst_busy), .cfg(cfg));

   assign rst_req_o = rst_busy;

   // R10
   sts_por_only_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req_o) |-> $stable(cfg.sts) || cfg.sts);
endmodule

// File: tb/pwrfail_supervisor_bench.sv
module pwrfail_supervisor_bench;
   localparam int CLK_P = 10;
   localparam int F     = 4;
   localparam int H     = 5;
   localparam logic [7:0] RA = 8'hEF;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       supply_low = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       clk_en, rst_req;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   pwrfail_supervisor #(.FILT_CYCLES(F), .RST_HOLD(H)) u_pwrfail_supervisor (
      .clk(clk), .por_n(por_n), .supply_low_i(supply_low),
      .reg_addr(addr), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
      .clk_en_o(clk_en), .rst_req_o(rst_req));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
      @(negedge clk);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // pulse of L edges in the given mode; expected levels from R4..R6 windows
   task automatic pulse(input int mode, input int len);
      int det;
      det = (len >= F);
      wr(RA, 8'(mode << 1));          // enable, pick mode, clear status
      rd_chk("R11", RA, mode << 1);
      supply_low = 1'b1;              // at a negedge: high before edge 1
      for (int t = 1; t <= F + H + 8; t++) begin
         @(posedge clk);
         @(negedge clk);
         if (mode == 0)
            chk("R5", clk_en, (det && t >= 2 + F && t <= len + 2) ? 0 : 1);
         else begin
            chk("R6", rst_req, (det && t >= 3 + F && t <= len + 2 + H) ? 1 : 0);
            chk("R6", clk_en, 1);
         end
         if (t == len) supply_low = 1'b0;
      end
      if (mode == 0) rd_chk("R4", RA, det ? 8'h01 : 8'h00);
      else           rd_chk("R8", RA, det ? 8'h05 : 8'h02);
   endtask

   initial begin : watchdog
      #(CLK_P * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      idle(3);
      por_n = 1'b1;
      idle(2);
      // R1 reset state
      rd_chk("R1", RA, 8'h04);
      chk("R1", clk_en, 1);
      chk("R1", rst_req, 0);
      // R2 other address reads zero and ignores writes
      rd_chk("R2", 8'hEE, 8'h00);
      wr(8'hEE, 8'h00);
      rd_chk("R2", RA, 8'h04);
      // R11 writes set fields; R2 reserved bits read zero
      wr(RA, 8'hFA);
      rd_chk("R2", RA, 8'h02);
      wr(RA, 8'h04);
      // R3 disabled: long dip ignored
      supply_low = 1'b1;
      for (int t = 0; t < 3 * F; t++) begin
         @(negedge clk);
         chk("R3", clk_en, 1);
         chk("R3", rst_req, 0);
      end
      supply_low = 1'b0;
      rd_chk("R3", RA, 8'h04);
      // R4/R5/R6 sweep over pulse lengths and modes
      for (int m = 0; m < 2; m++)
         for (int l = 1; l <= F + 2; l++)
            pulse(m, l);
      // R9 clearing write during an ongoing detection loses
      wr(RA, 8'h00);
      supply_low = 1'b1;
      idle(F + 4);
      chk("R5", clk_en, 0);
      wr(RA, 8'h00);
      rd_chk("R9", RA, 8'h01);
      supply_low = 1'b0;
      idle(4);
      chk("R5", clk_en, 1);
      // R9 write 1 keeps it, write 0 clears
      wr(RA, 8'h01);
      rd_chk("R9", RA, 8'h01);
      wr(RA, 8'h00);
      rd_chk("R9", RA, 8'h00);
      wr(RA, 8'h01);
      rd_chk("R9", RA, 8'h00);
      // R8 writes ignored during reset request; R10 status survives it
      wr(RA, 8'h02);
      supply_low = 1'b1;
      idle(F + 5);
      chk("R6", rst_req, 1);
      wr(RA, 8'h00);
      supply_low = 1'b0;
      idle(H + 6);
      chk("R6", rst_req, 0);
      rd_chk("R10", RA, 8'h05);
      // R10 cold start clears status
      @(negedge clk);
      por_n = 1'b0;
      idle(2);
      por_n = 1'b1;
      rd_chk("R10", RA, 8'h04);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule